// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Status-Code Handshake

This block is a master-only I2C controller that moves one bus action at a time: a start, a repeated start, one byte out, one byte in, or a stop. Software drives it through two writable registers, control and data, and reads a third register that holds an 8-bit status code. Each finished action raises an event flag in the control register and loads a code that names the event. While the flag is set, the controller keeps SCL pulled low and does nothing else. The write that clears the flag starts the next action.

The action that follows a clear depends on what the control register holds at that moment. A pending stop request wins. A start request left set gives a repeated start. Otherwise one byte moves. The first byte after a start or repeated start is the address byte, and its bit 0 sets the direction of the bytes that follow it. The data byte to send and the acknowledge choice for a byte to receive are taken when the flag is cleared, so values written before the clear are the ones used. Both bus lines are open-drain: an enable output pulls the line low, and the block reads the resolved SDA level back.

Top module: `i2cm_top`

## Requirements
- R1: After reset, the control and data registers read 0x00, the status register reads 0xF8, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: Register select 0 is control and select 1 is data. Control bit 6 is enable, bit 5 is start request, bit 4 is stop request, bit 3 is the event flag and bit 2 is assert-acknowledge. With enable and start set and the flag clear, an idle master pulls SDA low while SCL is high, then pulls SCL low. It then sets the flag and reports 0x08.
- R3: While the event flag is set, SCL produces no pulses. A register write that leaves the flag set does not move the bus.
- R4: Writing 1 to the event flag has no effect, and only the hardware sets it. A control write with the flag bit 0 that clears a set flag launches the next action, using the data register and the assert-acknowledge bit as they stand after that write.
- R5: The first byte after a start or repeated start goes out MSB first. If its bit 0 is 0, the status reads 0x18 on ACK and 0x20 on NACK. If its bit 0 is 1, it reads 0x40 on ACK and 0x48 on NACK.
- R6: A data byte sent after a write address goes out MSB first and reports 0x28 on ACK or 0x30 on NACK.
- R7: A data byte received after a read address is stored in the data register. The master drives ACK (SDA low) in the ninth clock when assert-acknowledge is 1 and reports 0x50. When it is 0, the master leaves SDA released (NACK) and reports 0x58.
- R8: If the start request is still set when the flag is cleared after a byte, the master generates a repeated start and reports 0x10.
- R9: If the stop request is set when the flag is cleared, the master raises SDA while SCL is high and releases both lines. The hardware then clears the stop bit, the flag stays clear, and the status reads 0xF8.
- R10: If the master releases SDA to send a 1 and reads SDA low at the end of that SCL high time, it releases both lines, sets the flag and reports 0x38.
- R11: During a byte, each SCL high time and each low time lasts `clk_div` clocks (values below 2 count as 2). SDA changes only while SCL is low.
- R12: Clearing enable releases both lines, clears the event flag, sets the status to 0xF8 and returns the master to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Write data |
| clk_div | input | DIVW | Clocks per SCL half period |
| sda_i | input | 1 | Resolved SDA line level |
| ctrl_rd | output | 8 | Control register contents |
| data_rd | output | 8 | Data register contents |
| status_rd | output | 8 | Last status code |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong internal state shows up on the bus lines within one SCL half period. Possible faults are a bit counter that is off by one, an address phase that is taken from the wrong byte, or a direction bit that is latched wrongly. Such a fault gives a captured byte that differs from the byte written, or a status code from the wrong group, at the next flag. A hold state that leaks shows up as SCL edges counted while the flag is set. A broken start or stop sequence shows up as a missing SDA edge while SCL is high. Timer faults show as a measured SCL high time that differs from `clk_div`.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int unsigned BIT_EN   = 6;
    localparam int unsigned BIT_STA  = 5;
    localparam int unsigned BIT_STO  = 4;
    localparam int unsigned BIT_FLAG = 3;
    localparam int unsigned BIT_AA   = 2;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    localparam logic [7:0] CODE_START   = 8'h08;
    localparam logic [7:0] CODE_RESTART = 8'h10;
    localparam logic [7:0] CODE_AW_ACK  = 8'h18;
    localparam logic [7:0] CODE_AW_NACK = 8'h20;
    localparam logic [7:0] CODE_TX_ACK  = 8'h28;
    localparam logic [7:0] CODE_TX_NACK = 8'h30;
    localparam logic [7:0] CODE_ARB     = 8'h38;
    localparam logic [7:0] CODE_AR_ACK  = 8'h40;
    localparam logic [7:0] CODE_AR_NACK = 8'h48;
    localparam logic [7:0] CODE_RX_ACK  = 8'h50;
    localparam logic [7:0] CODE_RX_NACK = 8'h58;
    localparam logic [7:0] CODE_IDLE    = 8'hF8;

    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic flag;
        logic aa;
    } ctrl_t;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SEQ,
        ENG_XFER,
        ENG_HOLD,
        ENG_LOST
    } eng_e;

    typedef enum logic [1:0] {
        SEQ_START,
        SEQ_RSTART,
        SEQ_STOP
    } seq_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    function automatic logic [7:0] ctrl_pack(input ctrl_t c);
        logic [7:0] v;
        v = 8'h00;
        v[BIT_EN]   = c.en;
        v[BIT_STA]  = c.sta;
        v[BIT_STO]  = c.sto;
        v[BIT_FLAG] = c.flag;
        v[BIT_AA]   = c.aa;
        return v;
    endfunction

    // Line levels for each step of the start, repeated start and stop sequences.
    function automatic pins_t seq_pins(input seq_e k, input logic [1:0] step);
        pins_t p;
        p = '{scl_low: 1'b0, sda_low: 1'b0};
        case (k)
            SEQ_START: begin
                p.sda_low = 1'b1;
                p.scl_low = (step == 2'd1);
            end
            SEQ_RSTART: begin
                p.sda_low = (step >= 2'd2);
                p.scl_low = (step == 2'd0) || (step == 2'd3);
            end
            SEQ_STOP: begin
                p.scl_low = (step == 2'd0);
                p.sda_low = (step != 2'd2);
            end
            default: p = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic [1:0] seq_last(input seq_e k);
        case (k)
            SEQ_START:  return 2'd1;
            SEQ_RSTART: return 2'd3;
            default:    return 2'd2;
        endcase
    endfunction

    function automatic logic [7:0] xfer_code(input logic is_addr, input logic rx, input logic ackd);
        if (is_addr) begin
            if (rx) return ackd ? CODE_AR_ACK : CODE_AR_NACK;
            return ackd ? CODE_AW_ACK : CODE_AW_NACK;
        end
        if (rx) return ackd ? CODE_RX_ACK : CODE_RX_NACK;
        return ackd ? CODE_TX_ACK : CODE_TX_NACK;
    endfunction

endpackage

// File: rtl/i2cm_divider.sv
module i2cm_divider #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [DIVW-1:0] div,
    output logic            tick_done,
    output logic            tick_zero
);
    localparam logic [DIVW-1:0] MIN_DIV = DIVW'(2);

    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    always_comb begin
        lim       = (div < MIN_DIV) ? MIN_DIV : div;
        tick_done = (cnt == lim - DIVW'(1));
        tick_zero = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || hold || tick_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIVW'(1);
        end
    end

    // R11
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (cnt < lim));

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       evt,
    input  logic [7:0] evt_code,
    input  logic       rx_load,
    input  logic [7:0] rx_byte,
    input  logic       stop_done,
    output ctrl_t      ctrl,
    output logic [7:0] data_q,
    output logic [7:0] status_q,
    output logic       launch
);
    logic ctrl_wr;
    logic data_wr;

    always_comb begin
        ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
        data_wr = reg_wr && (reg_sel == SEL_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            data_q   <= 8'h00;
            status_q <= CODE_IDLE;
            launch   <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (ctrl_wr) begin
                ctrl.en  <= reg_wdata[BIT_EN];
                ctrl.sta <= reg_wdata[BIT_STA];
                ctrl.sto <= reg_wdata[BIT_STO];
                ctrl.aa  <= reg_wdata[BIT_AA];
                if (ctrl.flag && !reg_wdata[BIT_FLAG]) begin
                    ctrl.flag <= 1'b0;
                    launch    <= reg_wdata[BIT_EN];
                end
            end
            if (data_wr) begin
                data_q <= reg_wdata;
            end
            if (evt) begin
                ctrl.flag <= 1'b1;
                status_q  <= evt_code;
            end
            if (rx_load) begin
                data_q <= rx_byte;
            end
            if (stop_done) begin
                ctrl.sto <= 1'b0;
                status_q <= CODE_IDLE;
            end
            if (!ctrl.en) begin
                ctrl.flag <= 1'b0;
                status_q  <= CODE_IDLE;
            end
        end
    end

    // R4
    flag_hw_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.flag) |-> $past(evt));

    // R4
    launch_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> ($past(ctrl.flag) && !ctrl.flag));

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_t      ctrl,
    input  logic       launch,
    input  logic [7:0] data_q,
    input  logic       sda_i,
    input  logic       tick_done,
    input  logic       tick_zero,
    output logic       tick_hold,
    output logic       scl_q,
    output logic       sda_q,
    output logic       evt,
    output logic [7:0] evt_code,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic       stop_done
);
    eng_e       st;
    seq_e       kind;
    logic [1:0] step;
    logic [3:0] bitn;
    logic       high;
    logic [7:0] sh;
    logic       addr_ph;
    logic       rx_mode;
    logic       cur_addr;
    logic       cur_rx;
    logic       ack_drv;
    pins_t      nxt_pins;
    logic       ack_seen;

    always_comb begin
        tick_hold = (st == ENG_IDLE) || (st == ENG_HOLD) || (st == ENG_LOST);
        nxt_pins  = seq_pins(kind, step + 2'd1);
        ack_seen  = cur_rx ? ack_drv : !sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en) begin
            st        <= ENG_IDLE;
            kind      <= SEQ_START;
            step      <= 2'd0;
            bitn      <= 4'd0;
            high      <= 1'b0;
            sh        <= 8'h00;
            addr_ph   <= 1'b0;
            rx_mode   <= 1'b0;
            cur_addr  <= 1'b0;
            cur_rx    <= 1'b0;
            ack_drv   <= 1'b0;
            scl_q     <= 1'b0;
            sda_q     <= 1'b0;
            evt       <= 1'b0;
            evt_code  <= CODE_IDLE;
            rx_load   <= 1'b0;
            rx_byte   <= 8'h00;
            stop_done <= 1'b0;
        end else begin
            evt       <= 1'b0;
            rx_load   <= 1'b0;
            stop_done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                    if (ctrl.sta && !ctrl.flag) begin
                        st    <= ENG_SEQ;
                        kind  <= SEQ_START;
                        step  <= 2'd0;
                        {scl_q, sda_q} <= seq_pins(SEQ_START, 2'd0);
                    end
                end
                ENG_HOLD: begin
                    if (launch) begin
                        if (ctrl.sto) begin
                            st   <= ENG_SEQ;
                            kind <= SEQ_STOP;
                            step <= 2'd0;
                            {scl_q, sda_q} <= seq_pins(SEQ_STOP, 2'd0);
                        end else if (ctrl.sta) begin
                            st   <= ENG_SEQ;
                            kind <= SEQ_RSTART;
                            step <= 2'd0;
                            {scl_q, sda_q} <= seq_pins(SEQ_RSTART, 2'd0);
                        end else begin
                            st       <= ENG_XFER;
                            sh       <= data_q;
                            cur_addr <= addr_ph;
                            cur_rx   <= addr_ph ? 1'b0 : rx_mode;
                            ack_drv  <= ctrl.aa;
                            bitn     <= 4'd0;
                            high     <= 1'b0;
                            if (addr_ph) begin
                                rx_mode <= data_q[0];
                            end
                        end
                    end
                end
                ENG_SEQ: begin
                    if (tick_done) begin
                        if (step == seq_last(kind)) begin
                            if (kind == SEQ_STOP) begin
                                st        <= ENG_IDLE;
                                stop_done <= 1'b1;
                                addr_ph   <= 1'b0;
                            end else begin
                                st       <= ENG_HOLD;
                                addr_ph  <= 1'b1;
                                evt      <= 1'b1;
                                evt_code <= (kind == SEQ_START) ? CODE_START : CODE_RESTART;
                            end
                        end else begin
                            step <= step + 2'd1;
                            {scl_q, sda_q} <= nxt_pins;
                        end
                    end
                end
                ENG_XFER: begin
                    if (!high) begin
                        scl_q <= 1'b1;
                        if (tick_zero) begin
                            if (bitn[3]) begin
                                sda_q <= cur_rx ? ack_drv : 1'b0;
                            end else begin
                                sda_q <= cur_rx ? 1'b0 : !sh[7];
                            end
                        end
                        if (tick_done) begin
                            high  <= 1'b1;
                            scl_q <= 1'b0;
                        end
                    end else if (tick_done) begin
                        if (!bitn[3]) begin
                            if (!cur_rx && !sda_q && !sda_i) begin
                                st       <= ENG_LOST;
                                scl_q    <= 1'b0;
                                sda_q    <= 1'b0;
                                evt      <= 1'b1;
                                evt_code <= CODE_ARB;
                                addr_ph  <= 1'b0;
                            end else begin
                                sh    <= {sh[6:0], sda_i};
                                bitn  <= bitn + 4'd1;
                                high  <= 1'b0;
                                scl_q <= 1'b1;
                            end
                        end else begin
                            st       <= ENG_HOLD;
                            scl_q    <= 1'b1;
                            high     <= 1'b0;
                            evt      <= 1'b1;
                            evt_code <= xfer_code(cur_addr, cur_addr ? rx_mode : cur_rx, ack_seen);
                            addr_ph  <= 1'b0;
                            if (cur_rx) begin
                                rx_load <= 1'b1;
                                rx_byte <= sh;
                            end
                        end
                    end
                end
                ENG_LOST: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                    if (launch) begin
                        st <= ENG_IDLE;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R11
    sda_moves_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_XFER && $past(st) == ENG_XFER && !scl_q && !$past(scl_q)) |-> $stable(sda_q));

    // R3
    hold_keeps_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_HOLD && $past(st) == ENG_HOLD) |-> scl_q);

    // R9
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        stop_done |-> (!scl_q && !sda_q));

    // R10
    lost_releases_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_LOST && $past(st) == ENG_LOST) |-> (!scl_q && !sda_q));

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    input  logic [DIVW-1:0] clk_div,
    input  logic            sda_i,
    output logic [7:0]      ctrl_rd,
    output logic [7:0]      data_rd,
    output logic [7:0]      status_rd,
    output logic            scl_oe,
    output logic            sda_oe
);
    ctrl_t      ctrl;
    logic [7:0] data_q;
    logic       launch;
    logic       evt;
    logic [7:0] evt_code;
    logic       rx_load;
    logic [7:0] rx_byte;
    logic       stop_done;
    logic       tick_hold;
    logic       tick_done;
    logic       tick_zero;

    i2cm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .evt       (evt),
        .evt_code  (evt_code),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .stop_done (stop_done),
        .ctrl      (ctrl),
        .data_q    (data_q),
        .status_q  (status_rd),
        .launch    (launch)
    );

    i2cm_divider #(.DIVW(DIVW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .hold      (tick_hold),
        .div       (clk_div),
        .tick_done (tick_done),
        .tick_zero (tick_zero)
    );

    i2cm_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .launch    (launch),
        .data_q    (data_q),
        .sda_i     (sda_i),
        .tick_done (tick_done),
        .tick_zero (tick_zero),
        .tick_hold (tick_hold),
        .scl_q     (scl_oe),
        .sda_q     (sda_oe),
        .evt       (evt),
        .evt_code  (evt_code),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .stop_done (stop_done)
    );

    always_comb begin
        ctrl_rd = ctrl_pack(ctrl);
        data_rd = data_q;
    end

    // R3
    frozen_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flag && $past(ctrl.flag)) |-> $stable(scl_oe));

    // R12
    disabled_released_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !$past(ctrl.en)) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2cm_top_test.sv
module i2cm_top_test;
    localparam int DIVW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic            reg_sel = 1'b0;
    logic [7:0]      reg_wdata = 8'h00;
    logic [DIVW-1:0] clk_div = DIVW'(4);
    logic            slave_pull = 1'b0;
    logic [7:0]      ctrl_rd, data_rd, status_rd;
    logic            scl_oe, sda_oe;

    wire scl_line = !scl_oe;
    wire sda_line = !sda_oe && !slave_pull;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    int starts = 0;
    int stops  = 0;
    int hi_run = 0;
    int last_hi = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;

    always #10 clk = !clk;

    i2cm_top #(.DIVW(DIVW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .clk_div(clk_div), .sda_i(sda_line),
        .ctrl_rd(ctrl_rd), .data_rd(data_rd), .status_rd(status_rd),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (scl_line && !prev_scl) rises++;
        if (scl_line && prev_scl && prev_sda && !sda_line) starts++;
        if (scl_line && prev_scl && !prev_sda && sda_line) stops++;
        if (scl_line) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!ctrl_rd[3] && n < 20000) begin @(negedge clk); n++; end
        chk(req, int'(ctrl_rd[3]), 1);
        idle(2);
    endtask

    task automatic wait_stop(input string req);
        int n = 0;
        while (ctrl_rd[4] && n < 20000) begin @(negedge clk); n++; end
        idle(2 * int'(clk_div) + 4);
        chk(req, int'(ctrl_rd[4]), 0);
    endtask

    task automatic bus_tx(output logic [7:0] seen, input logic give_ack);
        seen = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line); #1;
            seen = {seen[6:0], sda_line};
        end
        @(negedge scl_line); #1;
        slave_pull = give_ack;
        @(posedge scl_line);
        @(negedge scl_line); #1;
        slave_pull = 1'b0;
    endtask

    task automatic bus_rx(input logic [7:0] b, output logic ack_level);
        for (int i = 0; i < 8; i++) begin
            slave_pull = !b[7-i];
            @(posedge scl_line);
            @(negedge scl_line); #1;
        end
        slave_pull = 1'b0;
        @(posedge scl_line); #1;
        ack_level = sda_line;
        @(negedge scl_line); #1;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", int'(ctrl_rd), 'h00);
        chk("R1 data", int'(data_rd), 'h00);
        chk("R1 status", int'(status_rd), 'hF8);
        chk("R1 lines", int'({scl_oe, sda_oe}), 0);
    endtask

    task automatic t_flag_ignored;
        int r0;
        r0 = rises;
        wr(1'b0, 8'h48);
        idle(30);
        chk("R4 flag write ignored", int'(ctrl_rd), 'h40);
        chk("R4 no bus motion", rises - r0, 0);
    endtask

    task automatic t_start_and_freeze;
        int s0, r0;
        s0 = starts;
        wr(1'b0, 8'h60);
        wait_flag("R2 flag");
        chk("R2 status", int'(status_rd), 'h08);
        chk("R2 start edge", starts - s0, 1);
        chk("R2 lines low", int'({scl_line, sda_line}), 0);
        r0 = rises;
        wr(1'b0, 8'h48);
        wr(1'b1, 8'h11);
        idle(60);
        chk("R3 frozen", rises - r0, 0);
        chk("R3 flag kept", int'(ctrl_rd), 'h48);
    endtask

    task automatic t_addr_write;
        logic [7:0] seen;
        wr(1'b1, 8'hA6);
        wr(1'b0, 8'h40);
        bus_tx(seen, 1'b1);
        wait_flag("R5 flag");
        chk("R4 last data used", int'(seen), 'hA6);
        chk("R5 write ack", int'(status_rd), 'h18);
        chk("R11 high time", last_hi, int'(clk_div));
    endtask

    task automatic t_data_tx(input logic [7:0] b, input logic ack, input logic [7:0] code);
        logic [7:0] seen;
        wr(1'b1, b);
        wr(1'b0, 8'h40);
        bus_tx(seen, ack);
        wait_flag("R6 flag");
        chk("R6 byte", int'(seen), int'(b));
        chk("R6 status", int'(status_rd), int'(code));
    endtask

    task automatic t_restart_read;
        logic [7:0] seen;
        wr(1'b0, 8'h60);
        wait_flag("R8 flag");
        chk("R8 status", int'(status_rd), 'h10);
        wr(1'b1, 8'hA7);
        wr(1'b0, 8'h44);
        bus_tx(seen, 1'b1);
        wait_flag("R5 flag");
        chk("R5 read addr byte", int'(seen), 'hA7);
        chk("R5 read ack", int'(status_rd), 'h40);
    endtask

    task automatic t_rx(input logic [7:0] b, input logic aa);
        logic ack_level;
        wr(1'b0, aa ? 8'h44 : 8'h40);
        bus_rx(b, ack_level);
        wait_flag("R7 flag");
        chk("R7 data", int'(data_rd), int'(b));
        chk("R7 status", int'(status_rd), aa ? 'h50 : 'h58);
        chk("R7 ack level", int'(ack_level), aa ? 0 : 1);
    endtask

    task automatic t_stop;
        int p0;
        p0 = stops;
        wr(1'b0, 8'h50);
        wait_stop("R9 stop bit");
        chk("R9 status", int'(status_rd), 'hF8);
        chk("R9 ctrl", int'(ctrl_rd), 'h40);
        chk("R9 lines", int'({scl_oe, sda_oe}), 0);
        chk("R9 stop edge", stops - p0, 1);
    endtask

    task automatic t_addr_nack;
        logic [7:0] seen;
        wr(1'b0, 8'h60);
        wait_flag("R2 flag");
        wr(1'b1, 8'h91);
        wr(1'b0, 8'h40);
        bus_tx(seen, 1'b0);
        wait_flag("R5 flag");
        chk("R5 read nack", int'(status_rd), 'h48);
        t_stop();
    endtask

    task automatic t_arb;
        int r0;
        wr(1'b0, 8'h60);
        wait_flag("R2 flag");
        wr(1'b1, 8'h80);
        slave_pull = 1'b1;
        wr(1'b0, 8'h40);
        wait_flag("R10 flag");
        chk("R10 status", int'(status_rd), 'h38);
        chk("R10 lines", int'({scl_oe, sda_oe}), 0);
        r0 = rises;
        idle(40);
        chk("R3 no clock after loss", rises - r0, 0);
        slave_pull = 1'b0;
        wr(1'b0, 8'h40);
        idle(10);
    endtask

    task automatic t_disable;
        wr(1'b0, 8'h60);
        wait_flag("R2 flag");
        wr(1'b0, 8'h08);
        idle(6);
        chk("R12 ctrl", int'(ctrl_rd), 'h00);
        chk("R12 status", int'(status_rd), 'hF8);
        chk("R12 lines", int'({scl_oe, sda_oe}), 0);
    endtask

    task automatic t_slow_divider;
        logic [7:0] seen;
        clk_div = DIVW'(7);
        wr(1'b0, 8'h60);
        wait_flag("R2 flag");
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h40);
        bus_tx(seen, 1'b1);
        wait_flag("R11 flag");
        chk("R11 high time 7", last_hi, 7);
        chk("R5 byte", int'(seen), 'h55);
        t_stop();
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_flag_ignored();
        t_start_and_freeze();
        t_addr_write();
        t_data_tx(8'h5B, 1'b0, 8'h30);
        t_data_tx(8'hC3, 1'b1, 8'h28);
        t_restart_read();
        t_rx(8'h9D, 1'b1);
        t_rx(8'h2E, 1'b0);
        t_stop();
        t_addr_nack();
        t_arb();
        t_disable();
        wr(1'b0, 8'h40);
        t_slow_divider();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule